// File: doc/BRIEF.md
# Interleaved Operand SRAM Loader

This block takes one operand at a time for a modular-exponentiation engine and writes it into the engine's operand SRAM, which uses 32-bit words. Software or a DMA front end gives a start pulse with an operand kind and a byte length. It then streams the bytes most significant first over a valid/ready byte interface. The loader turns the string into SRAM writes with byte enables. Every twelve-dword group of the SRAM holds four exponent dwords, then four modulus dwords, then four message dwords.

Exponent and modulus operands are treated as numbers. Leading zero bytes are skipped. The remaining bytes are packed into little-endian dwords, least significant dword first, and the significant bit count is reported. The message is written one byte at a time, least significant byte first. The rest of the message region is then overwritten with zeros, so no data from an earlier message is left behind. Lengths the engine cannot hold, and the reserved kind, are refused without any write. A one-cycle done pulse closes every operation, including a refused one.

Top module: `opnd_sram_loader`

## Requirements
- R1: The kind code on mode_i selects the operand: 0 is exponent, 1 is modulus, 2 is message, 3 is reserved. For an exponent, packed dword k is written with all four byte enables to SRAM dword (k/4)*12 + k%4. Byte lane j of dword k (bits 8j+7..8j) holds the byte of significance 4k+j, where significance 0 is the last byte streamed.
- R2: A modulus is packed like an exponent but goes to SRAM dword (k/4)*12 + 4 + k%4.
- R3: Leading zero bytes of an exponent or modulus produce no write. Only dwords 0 to ceil(n/4)-1 are written, where n is the number of bytes from the first nonzero byte on. A partly filled top dword has zeros in its upper lanes.
- R4: bit_cnt_o reports 8n minus the leading zero bits of the first nonzero byte. It is zero for an all-zero or zero-length operand, which writes nothing. It is cleared by an accepted start and is otherwise held.
- R5: Message byte of significance i goes to byte lane i%4 of SRAM dword (d/4)*12 + 8 + d%4, where d = i/4. Only that one lane is enabled.
- R6: After the last message byte, every message byte position from the length up to 2047 is written with zero. Lanes below the length in the first fill dword are not enabled.
- R7: A start is refused when the kind is 3, or an exponent or modulus is longer than 512 bytes, or a message is longer than 2048 bytes. A refused start sets err_o, makes no write, accepts no byte and leaves bit_cnt_o at zero. err_o is held until the next accepted start.
- R8: done_o is a single-cycle pulse that comes after the last write of an operation. in_ready_o is low except while bytes are being received. A start pulse during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| mode_i | input | 2 | Operand kind: 0 exponent, 1 modulus, 2 message, 3 reserved |
| len_i | input | 12 | Operand length in bytes |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte, most significant first |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| wr_en_o | output | 1 | SRAM write strobe |
| wr_addr_o | output | 11 | SRAM dword address |
| wr_data_o | output | 32 | SRAM write data |
| wr_be_o | output | 4 | SRAM byte enables, bit j for bits 8j+7..8j |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Last start was refused |
| bit_cnt_o | output | 13 | Significant bits of the last exponent or modulus |

## Verification
A wrong remaining-byte count misplaces every dword after it. It can show as early as the first SRAM write after the first nonzero byte, as a write to the wrong group or lane. A seen-nonzero flag set too early or too late writes an extra zero dword, or loses the top dword, at the start of the stream. Its bit count is then wrong at done. A fill counter or byte-enable fault only appears after the message stream has ended: a stale lane survives in the shadow of the SRAM, or the done pulse comes at the wrong time. Each operation is therefore compared against a full image of the written SRAM, not just the write sequence.

// File: rtl/oper_ld_pkg.sv
package oper_ld_pkg;

  typedef enum logic [1:0] {
    OP_EXP  = 2'd0,
    OP_MOD  = 2'd1,
    OP_MSG  = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RECV = 2'd1,
    S_FILL = 2'd2,
    S_DONE = 2'd3
  } ld_state_e;

  localparam int unsigned LANES   = 4;
  localparam int unsigned GRP_DW  = 12;
  localparam int unsigned EXP_OFS = 0;
  localparam int unsigned MOD_OFS = 4;
  localparam int unsigned MSG_OFS = 8;

  // dword index inside one operand region -> physical interleaved dword
  function automatic int unsigned grp_addr(input int unsigned idx, input int unsigned ofs);
    return (idx / LANES) * GRP_DW + ofs + (idx % LANES);
  endfunction

  // position of highest set bit plus one, 0 for a zero byte
  function automatic logic [3:0] sig_bits8(input logic [7:0] b);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = 4'(i + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/oper_ld_ctrl.sv
module oper_ld_ctrl
  import oper_ld_pkg::*;
#(
  parameter int KEY_MAX = 512,
  parameter int MSG_MAX = 2048,
  parameter int LW      = $clog2(MSG_MAX + 1),
  parameter int SW      = $clog2(MSG_MAX),
  parameter int FW      = $clog2(MSG_MAX / LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [LW-1:0] len_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          accept_o,
  output logic          clear_o,
  output logic [SW-1:0] sig_o,
  output op_kind_e      mode_o,
  output logic          fill_o,
  output logic [FW-1:0] fill_dw_o,
  output logic [3:0]    fill_be_o,
  output logic          idle_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int MSG_DW = MSG_MAX / LANES;

  ld_state_e     st_q;
  op_kind_e      mode_q;
  logic [LW-1:0] len_q, rem_q;
  logic [FW-1:0] fill_q;
  logic          err_q, done_q;
  logic          bad_req;

  always_comb begin
    bad_req = (mode_i == OP_RSVD) ||
              ((mode_i != OP_MSG) && (len_i > LW'(KEY_MAX))) ||
              ((mode_i == OP_MSG) && (len_i > LW'(MSG_MAX)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= OP_EXP;
      len_q  <= '0;
      rem_q  <= '0;
      fill_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == S_DONE);
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mode_q <= op_kind_e'(mode_i);
          len_q  <= len_i;
          rem_q  <= len_i;
          fill_q <= '0;
          err_q  <= bad_req;
          if (bad_req)               st_q <= S_DONE;
          else if (len_i == '0)      st_q <= (mode_i == OP_MSG) ? S_FILL : S_DONE;
          else                       st_q <= S_RECV;
        end
        S_RECV: if (in_valid_i) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LW'(1)) begin
            if ((mode_q == OP_MSG) && (len_q != LW'(MSG_MAX))) begin
              st_q   <= S_FILL;
              fill_q <= FW'(len_q >> 2);
            end else begin
              st_q <= S_DONE;
            end
          end
        end
        S_FILL: begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == FW'(MSG_DW - 1)) st_q <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // lanes at or beyond the message length are zero-filled
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      fill_be_o[j] = (LW'({fill_q, 2'(j)}) >= len_q);
    end
  end

  assign in_ready_o = (st_q == S_RECV);
  assign accept_o   = in_ready_o && in_valid_i;
  assign clear_o    = (st_q == S_IDLE) && start_i;
  assign sig_o      = SW'(rem_q - 1'b1);
  assign mode_o     = mode_q;
  assign fill_o     = (st_q == S_FILL);
  assign fill_dw_o  = fill_q;
  assign idle_o     = (st_q == S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/oper_ld_keypack.sv
module oper_ld_keypack
  import oper_ld_pkg::*;
#(
  parameter int SW  = 11,
  parameter int BCW = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           accept_i,
  input  logic           key_mode_i,
  input  logic [7:0]     byte_i,
  input  logic [SW-1:0]  sig_i,
  output logic           wr_req_o,
  output logic [SW-3:0]  wr_idx_o,
  output logic [31:0]    wr_data_o,
  output logic [BCW-1:0] bit_cnt_o
);

  logic [31:0]    acc_q, acc_nxt;
  logic           seen_q, take;
  logic [BCW-1:0] bit_cnt_q;

  always_comb begin
    take      = accept_i && key_mode_i && (seen_q || (byte_i != 8'h00));
    acc_nxt   = {acc_q[23:0], byte_i};
    wr_req_o  = take && (sig_i[1:0] == 2'b00);
    wr_idx_o  = sig_i[SW-1:2];
    wr_data_o = acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      seen_q    <= 1'b0;
      bit_cnt_q <= '0;
    end else if (clear_i) begin
      acc_q     <= '0;
      seen_q    <= 1'b0;
      bit_cnt_q <= '0;
    end else if (take) begin
      seen_q <= 1'b1;
      acc_q  <= (sig_i[1:0] == 2'b00) ? 32'h0 : acc_nxt;
      if (!seen_q) bit_cnt_q <= BCW'({sig_i, 3'b000}) + BCW'(sig_bits8(byte_i));
    end
  end

  assign bit_cnt_o = bit_cnt_q;

endmodule

// File: rtl/oper_ld_wrport.sv
module oper_ld_wrport
  import oper_ld_pkg::*;
#(
  parameter int SW = 11,
  parameter int FW = 9,
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_kind_e      mode_i,
  input  logic          key_req_i,
  input  logic [SW-3:0] key_idx_i,
  input  logic [31:0]   key_data_i,
  input  logic          msg_req_i,
  input  logic [SW-1:0] sig_i,
  input  logic [7:0]    byte_i,
  input  logic          fill_i,
  input  logic [FW-1:0] fill_dw_i,
  input  logic [3:0]    fill_be_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [3:0]    wr_be_o
);

  logic          en_d;
  logic [AW-1:0] addr_d;
  logic [31:0]   data_d;
  logic [3:0]    be_d;

  always_comb begin
    en_d   = 1'b0;
    addr_d = '0;
    data_d = '0;
    be_d   = '0;
    if (key_req_i) begin
      en_d   = 1'b1;
      addr_d = AW'(grp_addr(32'(key_idx_i), (mode_i == OP_MOD) ? MOD_OFS : EXP_OFS));
      data_d = key_data_i;
      be_d   = 4'hF;
    end else if (msg_req_i) begin
      en_d   = 1'b1;
      addr_d = AW'(grp_addr(32'(sig_i >> 2), MSG_OFS));
      data_d = {4{byte_i}};
      be_d   = 4'b0001 << sig_i[1:0];
    end else if (fill_i) begin
      en_d   = 1'b1;
      addr_d = AW'(grp_addr(32'(fill_dw_i), MSG_OFS));
      be_d   = fill_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
    end else begin
      wr_en_o   <= en_d;
      wr_addr_o <= addr_d;
      wr_data_o <= data_d;
      wr_be_o   <= be_d;
    end
  end

endmodule

// File: rtl/opnd_sram_loader.sv
module opnd_sram_loader
  import oper_ld_pkg::*;
#(
  parameter int KEY_MAX_BYTES = 512,
  parameter int MSG_MAX_BYTES = 2048,
  localparam int LW  = $clog2(MSG_MAX_BYTES + 1),
  localparam int SW  = $clog2(MSG_MAX_BYTES),
  localparam int FW  = $clog2(MSG_MAX_BYTES / LANES),
  localparam int AW  = $clog2((MSG_MAX_BYTES / LANES / LANES) * GRP_DW),
  localparam int BCW = $clog2(KEY_MAX_BYTES * 8 + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [LW-1:0]  len_i,
  input  logic           in_valid_i,
  input  logic [7:0]     in_data_i,
  output logic           in_ready_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [31:0]    wr_data_o,
  output logic [3:0]     wr_be_o,
  output logic           done_o,
  output logic           err_o,
  output logic [BCW-1:0] bit_cnt_o
);

  logic          accept_w, clear_w, fill_w, idle_w;
  logic [SW-1:0] sig_w;
  op_kind_e      mode_w;
  logic [FW-1:0] fill_dw_w;
  logic [3:0]    fill_be_w;
  logic          key_req_w;
  logic [SW-3:0] key_idx_w;
  logic [31:0]   key_data_w;

  oper_ld_ctrl #(
    .KEY_MAX(KEY_MAX_BYTES), .MSG_MAX(MSG_MAX_BYTES), .LW(LW), .SW(SW), .FW(FW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .len_i, .in_valid_i,
    .in_ready_o,
    .accept_o  (accept_w),
    .clear_o   (clear_w),
    .sig_o     (sig_w),
    .mode_o    (mode_w),
    .fill_o    (fill_w),
    .fill_dw_o (fill_dw_w),
    .fill_be_o (fill_be_w),
    .idle_o    (idle_w),
    .done_o,
    .err_o
  );

  oper_ld_keypack #(.SW(SW), .BCW(BCW)) u_pack (
    .clk_i, .rst_ni,
    .clear_i    (clear_w),
    .accept_i   (accept_w),
    .key_mode_i (mode_w != OP_MSG),
    .byte_i     (in_data_i),
    .sig_i      (sig_w),
    .wr_req_o   (key_req_w),
    .wr_idx_o   (key_idx_w),
    .wr_data_o  (key_data_w),
    .bit_cnt_o
  );

  oper_ld_wrport #(.SW(SW), .FW(FW), .AW(AW)) u_wr (
    .clk_i, .rst_ni,
    .mode_i     (mode_w),
    .key_req_i  (key_req_w),
    .key_idx_i  (key_idx_w),
    .key_data_i (key_data_w),
    .msg_req_i  (accept_w && (mode_w == OP_MSG)),
    .sig_i      (sig_w),
    .byte_i     (in_data_i),
    .fill_i     (fill_w),
    .fill_dw_i  (fill_dw_w),
    .fill_be_i  (fill_be_w),
    .wr_en_o, .wr_addr_o, .wr_data_o, .wr_be_o
  );

endmodule

// File: rtl/opnd_sram_loader_chk.sv
module opnd_sram_loader_chk
  import oper_ld_pkg::*;
#(
  parameter int AW  = 11,
  parameter int BCW = 13
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           in_ready_o,
  input logic           wr_en_o,
  input logic [AW-1:0]  wr_addr_o,
  input logic [3:0]     wr_be_o,
  input logic           done_o,
  input logic           err_o,
  input logic [BCW-1:0] bit_cnt_o,
  input op_kind_e       mode_q,
  input logic           idle
);

  // R1
  exp_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && (mode_q == OP_EXP) |-> (32'(wr_addr_o) % 12) < 4 && wr_be_o == 4'hF);

  // R2
  mod_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && (mode_q == OP_MOD) |-> (32'(wr_addr_o) % 12) >= 4 && (32'(wr_addr_o) % 12) < 8
                                      && wr_be_o == 4'hF);

  // R5
  msg_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && (mode_q == OP_MSG) |-> (32'(wr_addr_o) % 12) >= 8 && wr_be_o != 4'h0);

  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !start_i |=> $stable(bit_cnt_o) && $stable(err_o));

  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_en_o && !in_ready_o && bit_cnt_o == '0);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !in_ready_o && !wr_en_o);

endmodule

bind opnd_sram_loader opnd_sram_loader_chk #(.AW(AW), .BCW(BCW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .in_ready_o (in_ready_o),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .wr_be_o    (wr_be_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .bit_cnt_o  (bit_cnt_o),
  .mode_q     (mode_w),
  .idle       (idle_w)
);

// File: tb/sim_opnd_sram_loader.sv
`timescale 1ns/1ps
module sim_opnd_sram_loader;
  localparam int KEYB  = 512;
  localparam int MSGB  = 2048;
  localparam int DEPTH = 1536;
  localparam int NV    = 16;

  // {mode[47:44], len[43:28], lz[27:16], top[15:8], seed[7:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd0, 16'd5,    12'd1, 8'h01, 8'h10},  // exp, one leading zero (R3)
    {4'd1, 16'd8,    12'd0, 8'h80, 8'h22},  // mod, full dwords
    {4'd0, 16'd7,    12'd3, 8'h0F, 8'h31},  // exp, three leading zeros
    {4'd1, 16'd6,    12'd0, 8'h3C, 8'h44},  // mod, short top dword
    {4'd0, 16'd512,  12'd0, 8'hFF, 8'h05},  // exp, maximum length
    {4'd1, 16'd1,    12'd0, 8'h01, 8'h00},  // mod, single bit
    {4'd0, 16'd4,    12'd4, 8'h00, 8'h00},  // exp, all zero
    {4'd2, 16'd10,   12'd0, 8'hAB, 8'h17},  // msg, partial fill (R6)
    {4'd2, 16'd2048, 12'd0, 8'h5A, 8'h63},  // msg, no fill
    {4'd2, 16'd0,    12'd0, 8'h00, 8'h00},  // msg, all fill
    {4'd2, 16'd3,    12'd0, 8'hC1, 8'h2E},  // msg, fill from lane 3
    {4'd0, 16'd0,    12'd0, 8'h00, 8'h00},  // exp, zero length
    {4'd1, 16'd513,  12'd0, 8'h11, 8'h01},  // mod too long (R7)
    {4'd2, 16'd2049, 12'd0, 8'h11, 8'h01},  // msg too long
    {4'd3, 16'd4,    12'd0, 8'h11, 8'h01},  // reserved kind
    {4'd1, 16'd512,  12'd2, 8'h07, 8'h9D}   // mod, max with leading zeros
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [11:0] len = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, wr_en, done, err;
  logic [10:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic [12:0] bit_cnt;

  always #10 clk = ~clk;

  opnd_sram_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .len_i(len),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be),
    .done_o(done), .err_o(err), .bit_cnt_o(bit_cnt)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow   [DEPTH];
  logic [31:0] expect_m [DEPTH];
  logic [7:0]  src      [MSGB + 1];
  logic        clr_shadow = 1'b0;
  int          exp_bits;

  function automatic logic [31:0] marker(input int a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  always @(negedge clk) begin
    if (clr_shadow) begin
      for (int a = 0; a < DEPTH; a++) shadow[a] = marker(a);
    end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
      for (int j = 0; j < 4; j++)
        if (wr_be[j]) shadow[wr_addr][8*j +: 8] = wr_data[8*j +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  function automatic int map_dw(input int idx, input int ofs);
    return (idx / 4) * 12 + ofs + (idx % 4);
  endfunction

  function automatic int clz8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) if (b[i]) return 7 - i;
    return 8;
  endfunction

  task automatic build_src(input int n, input int lz, input logic [7:0] top, input logic [7:0] seed);
    for (int k = 0; k < MSGB + 1; k++) begin
      if (k >= n)       src[k] = 8'h00;
      else if (k < lz)  src[k] = 8'h00;
      else if (k == lz) src[k] = top;
      else              src[k] = 8'(int'(seed) + k * 29);
    end
  endtask

  task automatic build_expected(input int md, input int n);
    int f;
    logic [31:0] w;
    for (int a = 0; a < DEPTH; a++) expect_m[a] = marker(a);
    exp_bits = 0;
    if (md < 2 && n <= KEYB) begin
      f = n;
      for (int k = n - 1; k >= 0; k--) if (src[k] != 8'h00) f = k;
      if (f < n) begin
        exp_bits = 8 * (n - f) - clz8(src[f]);
        for (int k = 0; k < (n - f + 3) / 4; k++) begin
          w = '0;
          for (int j = 0; j < 4; j++)
            if (4*k + j < n - f) w[8*j +: 8] = src[n - 1 - (4*k + j)];
          expect_m[map_dw(k, md == 1 ? 4 : 0)] = w;
        end
      end
    end else if (md == 2 && n <= MSGB) begin
      for (int d = 0; d < MSGB / 4; d++) begin
        w = '0;
        for (int j = 0; j < 4; j++)
          if (4*d + j < n) w[8*j +: 8] = src[n - 1 - (4*d + j)];
        expect_m[map_dw(d, 8)] = w;
      end
    end
  endtask

  task automatic clear_shadow();
    @(posedge clk); clr_shadow = 1'b1;
    @(posedge clk); clr_shadow = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = 0;
    for (int a = 0; a < DEPTH; a++)
      if (shadow[a] !== expect_m[a]) begin
        if (bad == 0) first = a;
        bad++;
      end
    chk(bad == 0, req, {21'd0, 11'(first), shadow[first]}, {21'd0, 11'(first), expect_m[first]});
  endtask

  task automatic issue_start(input int md, input int n);
    @(negedge clk);
    start = 1'b1; mode = 2'(md); len = 12'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // caller is at a negedge; returns at a negedge
  task automatic send_bytes(input int from, input int upto, input bit gap);
    for (int k = from; k < upto; k++) begin
      in_valid = 1'b1; in_data = src[k];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (gap && k[0]) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, req, 64'(done), 64'd1);
  endtask

  task automatic run_op(input int md, input int n, input int lz, input logic [7:0] top,
                        input logic [7:0] seed, input bit gap);
    bit bad;
    string mt;
    bad = (md == 3) || (md < 2 && n > KEYB) || (md == 2 && n > MSGB);
    mt  = bad ? "R7" : (md == 0) ? "R1" : (md == 1) ? "R2" : (n < MSGB) ? "R6" : "R5";
    build_src(n > MSGB ? MSGB : n, lz, top, seed);
    build_expected(md, n);
    clear_shadow();
    issue_start(md, n);
    if (!bad && n > 0 && md < 3) send_bytes(0, n, gap);
    wait_done("R8 done");
    chk(err === bad, "R7 err", 64'(err), 64'(bad));
    chk(int'(bit_cnt) == exp_bits, "R4 bit count", 64'(bit_cnt), 64'(exp_bits));
    @(negedge clk);
    chk(done === 1'b0, "R8 done width", 64'(done), 64'd0);
    compare_mem(lz > 0 ? "R3" : mt);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] held;
    bit saw_ready;
    repeat (3) @(negedge clk);
    // reset state (R8, R4)
    chk(in_ready === 1'b0, "R8 reset ready", 64'(in_ready), 64'd0);
    chk(wr_en === 1'b0 && done === 1'b0, "R8 reset quiet", {wr_en, done}, 64'd0);
    chk(bit_cnt === 13'd0 && err === 1'b0, "R4 reset count", {err, bit_cnt}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_op(int'(VEC[v][47:44]), int'(VEC[v][43:28]), int'(VEC[v][27:16]),
             VEC[v][15:8], VEC[v][7:0], v[0]);

    // R4: bit count held while idle
    run_op(1, 6, 0, 8'h3C, 8'h44, 1'b0);
    held = bit_cnt;
    repeat (6) @(negedge clk);
    chk(bit_cnt === held, "R4 hold", 64'(bit_cnt), 64'(held));
    chk(in_ready === 1'b0, "R8 idle ready", 64'(in_ready), 64'd0);

    // R7: refused start accepts no byte while bytes are offered
    clear_shadow();
    issue_start(0, 600);
    saw_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'h55;
    for (int c = 0; c < 4; c++) begin
      if (in_ready) saw_ready = 1'b1;
      if (done) break;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_done("R7 refused done");
    chk(!saw_ready, "R7 no accept", 64'(saw_ready), 64'd0);
    for (int a = 0; a < DEPTH; a++) expect_m[a] = marker(a);
    @(negedge clk);
    compare_mem("R7 no write");

    // R8: start during reception ignored
    build_src(8, 1, 8'h2D, 8'h71);
    build_expected(1, 8);
    clear_shadow();
    issue_start(1, 8);
    send_bytes(0, 3, 1'b0);
    start = 1'b1; mode = 2'd2; len = 12'd4;
    @(negedge clk);
    start = 1'b0;
    send_bytes(3, 8, 1'b0);
    wait_done("R8 busy done");
    chk(int'(bit_cnt) == exp_bits, "R8 busy start bits", 64'(bit_cnt), 64'(exp_bits));
    @(negedge clk);
    compare_mem("R8 busy start image");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule